// File: doc/BRIEF.md
# Run-Time Self-Test Status Monitor

This block watches three subsystems of a closed-loop angular-rate sensor interface and reports, every cycle, whether each one is healthy. The sense loop is judged from its 1-bit modulator output: a stable loop toggles often, so a long run of identical bits means the loop has saturated or stalled. The drive loop is judged from its oscillation amplitude word. Each new sample of that word is compared against a programmable window. The clock generator is judged from a raw lock indication. This signal is synchronized and must stay high for a qualification period before it is trusted.

The three good flags are combined into a live fail output. A sticky fail latch records any transition of a good flag from healthy to unhealthy and holds until a clear input is pulsed. A supervisor can therefore poll the latch and still see short outages that have already recovered.

Top module: `selftest_monitor`

## Requirements
- R1: While reset is asserted and after it is released, senseOk, driveOk, lockOk and failSticky are 0 and failNow is 1, until the qualification rules below set a flag.
- R2: Only cycles with senseValid=1 count as sense samples. A sample equal to the previous one extends the run length; any other sample restarts it at 1. The sample that takes the run length above runLimit clears senseOk, and the flag reads 0 on the next cycle. A run of exactly runLimit bits causes no fault.
- R3: senseOk is set by the sense sample that completes RECOVER_LEN (default 1024) consecutive sense samples with no run violation. Cycles with senseValid=0 neither count toward that total nor break it.
- R4: A sample with ampValid=1 and ampLow <= ampWord <= ampHigh (both limits inclusive, unsigned) sets driveOk and restarts the out-of-window count.
- R5: driveOk is cleared only by the GLITCH_LEN-th (default 4) consecutive out-of-window amplitude sample. Fewer consecutive out-of-window samples, followed by an in-window sample, leave driveOk at 1.
- R6: lockRaw passes through a two-stage synchronizer. lockOk rises on the 256th consecutive cycle in which the synchronized lock is high, which is 258 clock edges after lockRaw rises. It falls on the third edge after lockRaw goes low.
- R7: failNow is 1 whenever any of senseOk, driveOk or lockOk is 0.
- R8: failSticky is set on the same edge that any good flag goes from 1 to 0. It holds until a cycle with clearFail=1 in which no flag falls. If a fall and clearFail occur in the same cycle, the set wins.
- R9: While ampValid=0, ampWord and the limits have no effect on driveOk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| senseValid | input | 1 | Sense bitstream sample strobe |
| senseBit | input | 1 | Sense modulator output bit |
| runLimit | input | RUN_W | Longest allowed run of equal sense bits |
| ampValid | input | 1 | Amplitude sample strobe |
| ampWord | input | AMP_W | Drive oscillation amplitude |
| ampHigh | input | AMP_W | Upper window limit (inclusive) |
| ampLow | input | AMP_W | Lower window limit (inclusive) |
| lockRaw | input | 1 | Asynchronous raw lock indication |
| clearFail | input | 1 | Clears the sticky fail latch |
| senseOk | output | 1 | Sense loop healthy |
| driveOk | output | 1 | Drive amplitude healthy |
| lockOk | output | 1 | Clock generator locked and qualified |
| failNow | output | 1 | Any subsystem currently unhealthy |
| failSticky | output | 1 | A health flag has fallen since the last clear |

## Verification
The assertions check, on every cycle, the local cause-and-effect rules. A rise of driveOk must follow an in-window strobed sample, and a fall must follow an out-of-window one. A fall of senseOk must coincide with a sense sample. lockOk must be low after three low lockRaw samples and can rise only after lockRaw was high. Every flag fall must set the latch, which must hold without a clear. Counting behaviour can only be shown by the bench scenarios: the exact 1024-sample recovery with strobe gaps, the 16-versus-17 run boundary, the 4-sample glitch filter being restarted by an in-window sample, the 258-edge lock qualification, and the priority of a fall over a simultaneous clear.

// File: rtl/stmon_pkg.sv
package stmon_pkg;

  // Conditions the datapath reports to the control each cycle
  typedef struct packed {
    logic runViol;    // current sense sample makes the run too long
    logic cleanDone;  // recovery count has reached its final value
    logic ampOutside; // current amplitude word lies outside the window
    logic badDone;    // out-of-window count has reached its final value
    logic lockHigh;   // synchronized lock level
    logic lockDone;   // lock qualification count has reached its final value
  } stmon_evt_t;

  // Counter strobes the control issues to the datapath
  typedef struct packed {
    logic cleanClr;
    logic cleanInc;
    logic badClr;
    logic badInc;
    logic lockClr;
    logic lockInc;
  } stmon_stb_t;

endpackage

// File: rtl/stmon_datapath.sv
module stmon_datapath
  import stmon_pkg::*;
#(
  parameter int RUN_W       = 8,
  parameter int AMP_W       = 16,
  parameter int RECOVER_LEN = 1024,
  parameter int GLITCH_LEN  = 4,
  parameter int LOCK_LEN    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             senseValid,
  input  logic             senseBit,
  input  logic [RUN_W-1:0] runLimit,
  input  logic [AMP_W-1:0] ampWord,
  input  logic [AMP_W-1:0] ampHigh,
  input  logic [AMP_W-1:0] ampLow,
  input  logic             lockRaw,
  input  stmon_stb_t       stb,
  output stmon_evt_t       evt
);

  localparam int RUNCNT_W = RUN_W + 1;
  localparam int CLEAN_W  = $clog2(RECOVER_LEN + 1);
  localparam int BAD_W    = $clog2(GLITCH_LEN + 1);
  localparam int LOCK_W   = $clog2(LOCK_LEN + 1);
  localparam logic [RUNCNT_W-1:0] RUN_MAX = '1;

  // ---------------- sense run-length tracking ----------------
  logic [RUNCNT_W-1:0] runLen;
  logic [RUNCNT_W-1:0] runNext;
  logic                prevBit;
  logic                havePrev;
  logic [CLEAN_W-1:0]  cleanCnt;

  always_comb begin
    if (havePrev && (senseBit == prevBit)) begin
      runNext = (runLen == RUN_MAX) ? runLen : runLen + RUNCNT_W'(1);
    end else begin
      runNext = RUNCNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen   <= '0;
      prevBit  <= 1'b0;
      havePrev <= 1'b0;
    end else if (senseValid) begin
      runLen   <= runNext;
      prevBit  <= senseBit;
      havePrev <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.cleanClr) begin
      cleanCnt <= '0;
    end else if (stb.cleanInc) begin
      cleanCnt <= cleanCnt + CLEAN_W'(1);
    end
  end

  // ---------------- amplitude window ----------------
  logic [BAD_W-1:0] badCnt;

  always_ff @(posedge clk) begin
    if (!rstN || stb.badClr) begin
      badCnt <= '0;
    end else if (stb.badInc) begin
      badCnt <= badCnt + BAD_W'(1);
    end
  end

  // ---------------- lock synchronizer and qualifier ----------------
  logic [SYNC_STAGES-1:0] syncReg;
  logic [LOCK_W-1:0]      lockCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= lockRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], lockRaw};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || stb.lockClr) begin
      lockCnt <= '0;
    end else if (stb.lockInc) begin
      lockCnt <= lockCnt + LOCK_W'(1);
    end
  end

  // ---------------- event reporting ----------------
  always_comb begin
    evt.runViol    = senseValid && (runNext > {1'b0, runLimit});
    evt.cleanDone  = (cleanCnt == CLEAN_W'(RECOVER_LEN - 1));
    evt.ampOutside = (ampWord > ampHigh) || (ampWord < ampLow);
    evt.badDone    = (badCnt == BAD_W'(GLITCH_LEN - 1));
    evt.lockHigh   = syncReg[SYNC_STAGES-1];
    evt.lockDone   = (lockCnt == LOCK_W'(LOCK_LEN - 1));
  end

endmodule

// File: rtl/stmon_ctrl.sv
module stmon_ctrl
  import stmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       senseValid,
  input  logic       ampValid,
  input  logic       clearFail,
  input  stmon_evt_t evt,
  output stmon_stb_t stb,
  output logic       senseOk,
  output logic       driveOk,
  output logic       lockOk,
  output logic       failSticky
);

  logic senseNext;
  logic driveNext;
  logic lockNext;
  logic dropEvt;
  logic stickyNext;

  always_comb begin
    stb       = '0;
    senseNext = senseOk;
    driveNext = driveOk;
    lockNext  = lockOk;

    // sense loop: run violation resets recovery, full recovery sets flag
    if (senseValid) begin
      if (evt.runViol) begin
        stb.cleanClr = 1'b1;
        senseNext    = 1'b0;
      end else if (evt.cleanDone) begin
        senseNext = 1'b1;
      end else begin
        stb.cleanInc = 1'b1;
      end
    end

    // drive amplitude: glitch-filtered window check
    if (ampValid) begin
      if (evt.ampOutside) begin
        if (evt.badDone) driveNext = 1'b0;
        else             stb.badInc = 1'b1;
      end else begin
        stb.badClr = 1'b1;
        driveNext  = 1'b1;
      end
    end

    // lock: immediate drop, qualified rise
    if (!evt.lockHigh) begin
      stb.lockClr = 1'b1;
      lockNext    = 1'b0;
    end else if (evt.lockDone) begin
      lockNext = 1'b1;
    end else begin
      stb.lockInc = 1'b1;
    end

    dropEvt    = (senseOk && !senseNext) || (driveOk && !driveNext) || (lockOk && !lockNext);
    stickyNext = dropEvt || (failSticky && !clearFail);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseOk    <= 1'b0;
      driveOk    <= 1'b0;
      lockOk     <= 1'b0;
      failSticky <= 1'b0;
    end else begin
      senseOk    <= senseNext;
      driveOk    <= driveNext;
      lockOk     <= lockNext;
      failSticky <= stickyNext;
    end
  end

endmodule

// File: rtl/selftest_monitor.sv
module selftest_monitor
  import stmon_pkg::*;
#(
  parameter int RUN_W       = 8,
  parameter int AMP_W       = 16,
  parameter int RECOVER_LEN = 1024,
  parameter int GLITCH_LEN  = 4,
  parameter int LOCK_LEN    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             senseValid,
  input  logic             senseBit,
  input  logic [RUN_W-1:0] runLimit,
  input  logic             ampValid,
  input  logic [AMP_W-1:0] ampWord,
  input  logic [AMP_W-1:0] ampHigh,
  input  logic [AMP_W-1:0] ampLow,
  input  logic             lockRaw,
  input  logic             clearFail,
  output logic             senseOk,
  output logic             driveOk,
  output logic             lockOk,
  output logic             failNow,
  output logic             failSticky
);

  stmon_evt_t evt;
  stmon_stb_t stb;

  stmon_datapath #(
    .RUN_W(RUN_W), .AMP_W(AMP_W), .RECOVER_LEN(RECOVER_LEN),
    .GLITCH_LEN(GLITCH_LEN), .LOCK_LEN(LOCK_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .senseValid(senseValid), .senseBit(senseBit),
    .runLimit(runLimit), .ampWord(ampWord), .ampHigh(ampHigh), .ampLow(ampLow),
    .lockRaw(lockRaw), .stb(stb), .evt(evt)
  );

  stmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .senseValid(senseValid), .ampValid(ampValid),
    .clearFail(clearFail), .evt(evt), .stb(stb), .senseOk(senseOk),
    .driveOk(driveOk), .lockOk(lockOk), .failSticky(failSticky)
  );

  assign failNow = !(senseOk && driveOk && lockOk);

endmodule

// File: rtl/stmon_checker.sv
module stmon_checker #(
  parameter int AMP_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             senseValid,
  input logic             ampValid,
  input logic [AMP_W-1:0] ampWord,
  input logic [AMP_W-1:0] ampHigh,
  input logic [AMP_W-1:0] ampLow,
  input logic             lockRaw,
  input logic             clearFail,
  input logic             senseOk,
  input logic             driveOk,
  input logic             lockOk,
  input logic             failSticky
);

  a_r2_sense_fall_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    $fell(senseOk) |-> $past(senseValid));

  a_r4_drive_rise_in_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveOk) |-> ($past(ampValid) && ($past(ampWord) <= $past(ampHigh))
                        && ($past(ampWord) >= $past(ampLow))));

  a_r5_drive_fall_out_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveOk) |-> ($past(ampValid) && (($past(ampWord) > $past(ampHigh))
                        || ($past(ampWord) < $past(ampLow)))));

  a_r6_lock_low_after_raw_low: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(lockRaw) && !$past(lockRaw, 2) && !$past(lockRaw, 3)) |-> !lockOk);

  a_r6_lock_rise_needs_raw: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOk) |-> $past(lockRaw, 3));

  a_r8_sticky_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(senseOk) || $fell(driveOk) || $fell(lockOk)) |-> failSticky);

  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    (failSticky && !clearFail) |=> failSticky);

endmodule

bind selftest_monitor stmon_checker #(.AMP_W(AMP_W)) u_stmon_chk (
  .clk(clk), .rstN(rstN), .senseValid(senseValid), .ampValid(ampValid),
  .ampWord(ampWord), .ampHigh(ampHigh), .ampLow(ampLow), .lockRaw(lockRaw),
  .clearFail(clearFail), .senseOk(senseOk), .driveOk(driveOk),
  .lockOk(lockOk), .failSticky(failSticky)
);

// File: tb/test_selftest_monitor.sv
`timescale 1ns/1ps
module test_selftest_monitor;

  localparam int RUN_W = 8;
  localparam int AMP_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             senseValid = 1'b0;
  logic             senseBit = 1'b0;
  logic [RUN_W-1:0] runLimit = 8'd16;
  logic             ampValid = 1'b0;
  logic [AMP_W-1:0] ampWord = '0;
  logic [AMP_W-1:0] ampHigh = 16'd1000;
  logic [AMP_W-1:0] ampLow = 16'd500;
  logic             lockRaw = 1'b0;
  logic             clearFail = 1'b0;
  logic             senseOk, driveOk, lockOk, failNow, failSticky;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // scoreboard: {senseOk, driveOk, lockOk, failNow, failSticky}
  logic [4:0] expQ[$];
  string      tagQ[$];
  logic       eSense = 0, eDrive = 0, eLock = 0, eSticky = 0;

  always #2 clk = ~clk;

  selftest_monitor i_selftest_monitor (
    .clk(clk), .rstN(rstN), .senseValid(senseValid), .senseBit(senseBit),
    .runLimit(runLimit), .ampValid(ampValid), .ampWord(ampWord),
    .ampHigh(ampHigh), .ampLow(ampLow), .lockRaw(lockRaw),
    .clearFail(clearFail), .senseOk(senseOk), .driveOk(driveOk),
    .lockOk(lockOk), .failNow(failNow), .failSticky(failSticky)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: push expected flags, derived from the bench model
  task automatic expect_now(input string tag);
    logic fNow;
    fNow = !(eSense && eDrive && eLock);
    expQ.push_back({eSense, eDrive, eLock, fNow, eSticky});
    tagQ.push_back(tag);
  endtask

  task automatic senseSample(input logic b);
    senseValid = 1'b1;
    senseBit   = b;
    cyc(1);
    senseValid = 1'b0;
  endtask

  task automatic ampSample(input logic [AMP_W-1:0] w);
    ampValid = 1'b1;
    ampWord  = w;
    cyc(1);
    ampValid = 1'b0;
  endtask

  // monitor: pops and compares after each falling edge
  always @(negedge clk) begin
    #1;
    while (expQ.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = {senseOk, driveOk, lockOk, failNow, failSticky};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s: actual {sense,drive,lock,failNow,sticky}=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    cyc(3);
    expect_now("R1 flags during reset");
    cyc(1);
    rstN = 1'b1;
    cyc(1);
    expect_now("R1 reset state after release");

    // R6 lock qualification
    lockRaw = 1'b1;
    cyc(257);
    expect_now("R6 lock not yet qualified at edge 257");
    cyc(1);
    eLock = 1;
    expect_now("R6 lock qualified at edge 258");

    // R4 window with inclusive limits
    ampSample(16'd750);
    eDrive = 1;
    expect_now("R4 in-window sample sets driveOk");
    ampSample(16'd1000);
    ampSample(16'd500);
    expect_now("R4 inclusive limits keep driveOk");

    // R3 recovery after 1024 clean samples
    for (int i = 0; i < 1023; i++) senseSample(i[0]);
    expect_now("R3 senseOk low after 1023 samples");
    senseSample(1'b1);
    eSense = 1;
    expect_now("R3 R7 senseOk after 1024 samples, failNow low");

    // R2 run boundary (last bit was 1)
    for (int i = 0; i < 16; i++) senseSample(1'b0);
    expect_now("R2 run of 16 allowed");
    senseSample(1'b0);
    eSense = 0; eSticky = 1;
    expect_now("R2 R8 run of 17 clears senseOk, sets sticky");

    // R9 word ignored without strobe
    ampWord = 16'd5000;
    cyc(10);
    expect_now("R9 unstrobed out-of-window word ignored");

    // R5 glitch filter
    for (int i = 0; i < 3; i++) ampSample(16'd2000);
    ampSample(16'd700);
    for (int i = 0; i < 3; i++) ampSample(16'd10);
    expect_now("R5 three bad samples after restart keep driveOk");
    ampSample(16'd10);
    eDrive = 0;
    expect_now("R5 fourth consecutive bad sample clears driveOk");

    // R8 clear without drop
    clearFail = 1'b1;
    cyc(1);
    clearFail = 1'b0;
    eSticky = 0;
    expect_now("R8 clear releases sticky, R7 failNow stays");

    // R3 recovery with strobe gaps (last bit was 0)
    for (int i = 0; i < 1024; i++) begin
      senseSample(~i[0]);
      cyc(1);
    end
    eSense = 1;
    ampSample(16'd600);
    eDrive = 1;
    expect_now("R3 recovery counts only strobed samples");

    // R6 lock drop latency
    lockRaw = 1'b0;
    cyc(2);
    expect_now("R6 lock still high two edges after raw drop");
    cyc(1);
    eLock = 0; eSticky = 1;
    expect_now("R6 R8 lock drops on third edge, sticky set");

    // R8 drop wins over clear
    lockRaw = 1'b1;
    cyc(258);
    eLock = 1;
    clearFail = 1'b1;
    cyc(1);
    clearFail = 1'b0;
    eSticky = 0;
    expect_now("R8 relock and clear");
    lockRaw = 1'b0;
    cyc(2);
    clearFail = 1'b1;
    cyc(1);
    clearFail = 1'b0;
    eLock = 0; eSticky = 1;
    expect_now("R8 drop wins over simultaneous clear");

    cyc(3);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule